// File: doc/BRIEF.md
# ATM Cell Transmit Formatter

This block pulls ATM cells out of a segmentation buffer, which it sees as a byte stream with valid/ready. It formats each cell for a PHY transmit bus that is 8 or 16 bits wide, and marks the first beat of every cell with a start-of-cell flag. The buffer supplies, for each cell, the routing bytes first, then the four header bytes, then the 48 payload bytes. The formatter adds the HEC byte when one is needed, and adds a zero pad byte when a 16-bit transfer would otherwise end on half a word.

Static configuration inputs set several things. They set how many routing bytes (0 to 3) go out ahead of each cell. They choose between a 52-byte cell with no HEC and a 53-byte cell, and they choose what the HEC position carries. They set the bus width, and a 16-bit alignment adjust moves the pad byte from the tail of the transfer to its head. The configuration is taken when a cell starts and held until that cell ends, so software can rewrite it at any time.

Top module: `atm_txfmt`

## Requirements
- R1: Ahead of the header, each cell sends `cfg_extra` (0 to 3) routing bytes, taken from the input stream in arrival order.
- R2: Each cell reads exactly `cfg_extra`+52 bytes from the input. It sends `cfg_extra`+52 data bytes when `cfg_cell52`=1 and `cfg_extra`+53 when `cfg_cell52`=0. In 16-bit mode a single 0x00 pad byte is added when that count is odd.
- R3: When `cfg_cell52`=0, the byte that follows the four header bytes is 0x00 if `cfg_hec_zero`=1, and `cfg_hec_byte` if `cfg_hec_zero`=0.
- R4: When `cfg_cell52`=1, no HEC byte is sent, and neither `cfg_hec_zero` nor `cfg_hec_byte` changes the output.
- R5: In 16-bit mode (`cfg_bus8`=0), the earlier byte of each pair is on `tx_data[15:8]` and the later byte on `tx_data[7:0]`, with at most one word every two cycles. In 8-bit mode each byte is on `tx_data[7:0]` and `tx_data[15:8]` is 0.
- R6: In 16-bit mode with an odd byte count and no alignment adjust in force, the low byte of the final word is 0x00.
- R7: In 16-bit mode with an odd byte count, `cfg_align`=1 and `cfg_extra` non-zero, the high byte of the first word is 0x00, the data follows it without a gap, and no pad goes at the end.
- R8: `cfg_align` has no effect when `cfg_extra`=0 or in 8-bit mode.
- R9: `tx_soc` is high only together with `tx_valid`, and only on the first beat of each cell.
- R10: Configuration is sampled when a cell starts. A change during a cell does not affect that cell, and it applies to the next one.
- R11: After reset `tx_valid` and `tx_soc` are low.
- R12: `in_ready` is high only when the next byte to send comes from the input. When `in_valid` is low the position in the cell is held, and no byte is skipped or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_extra | input | 2 | Number of routing bytes per cell |
| cfg_cell52 | input | 1 | 1: 52-byte cell without HEC |
| cfg_hec_zero | input | 1 | 1: HEC position carries 0x00 |
| cfg_hec_byte | input | 8 | Programmed HEC position value |
| cfg_bus8 | input | 1 | 1: 8-bit bus, 0: 16-bit bus |
| cfg_align | input | 1 | 16-bit pad-to-front adjust |
| in_data | input | 8 | Byte from segmentation buffer |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Formatter takes in_data this cycle |
| tx_data | output | 16 | Transmit bus word |
| tx_valid | output | 1 | tx_data holds a beat |
| tx_soc | output | 1 | First beat of a cell |

## Verification
The bench sweeps all 64 combinations of routing count, cell length, HEC source, bus width and alignment adjust. For each one it compares every beat with a layout it computes from the requirements. This catches several kinds of error. A pad placed at the wrong end, or applied when the routing count is zero, shifts every byte of the cell by one. Bytes swapped within a word show up in the first pair. A HEC byte sent in 52-byte mode makes the cell one byte too long. Separate runs do the following: they drop `in_valid` at intervals, to catch a design that skips or repeats a byte during a stall; they change the configuration in the middle of a cell, to catch a design that does not hold the configuration for the whole cell; and they check that `tx_soc` appears on no beat other than the first.

// File: rtl/atmtx_pkg.sv
package atmtx_pkg;
  localparam int BYTE_W    = 8;
  localparam int HDR_BYTES = 4;
  localparam int PAY_BYTES = 48;
  localparam int MAX_EXTRA = 3;
  localparam int EXTRA_W   = $clog2(MAX_EXTRA + 1);
  localparam int BASE_LEN  = HDR_BYTES + PAY_BYTES;
  localparam int SLOT_MAX  = BASE_LEN + 1 + MAX_EXTRA + 1;
  localparam int IDX_W     = $clog2(SLOT_MAX + 1);
  localparam int WORD_W    = 2 * BYTE_W;

  typedef enum logic [1:0] {
    SLOT_SRC = 2'd0,
    SLOT_HEC = 2'd1,
    SLOT_PAD = 2'd2
  } slot_e;

  typedef struct packed {
    logic [EXTRA_W-1:0] extra;
    logic               cell52;
    logic               hec_zero;
    logic [BYTE_W-1:0]  hec_byte;
    logic               bus8;
    logic               align;
  } cfg_t;
endpackage

// File: rtl/atmtx_slot.sv
module atmtx_slot
  import atmtx_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  cfg_t             cfg,
  output slot_e            kind,
  output logic             last
);
  logic [IDX_W-1:0] len;
  logic [IDX_W-1:0] total;
  logic [IDX_W-1:0] j;
  logic [IDX_W-1:0] h;
  logic             odd;
  logic             front;

  always_comb begin
    len   = IDX_W'(cfg.extra) + IDX_W'(BASE_LEN) + IDX_W'(!cfg.cell52);
    odd   = !cfg.bus8 && len[0];
    front = odd && cfg.align && (cfg.extra != '0);
    total = len + IDX_W'(odd);
    j     = idx - IDX_W'(front);
    h     = j - IDX_W'(cfg.extra);
    last  = (idx == total - IDX_W'(1));
    if (front && idx == '0)
      kind = SLOT_PAD;
    else if (odd && !front && last)
      kind = SLOT_PAD;
    else if (j < IDX_W'(cfg.extra))
      kind = SLOT_SRC;
    else if (!cfg.cell52 && h == IDX_W'(HDR_BYTES))
      kind = SLOT_HEC;
    else
      kind = SLOT_SRC;
  end
endmodule

// File: rtl/atmtx_seq.sv
module atmtx_seq
  import atmtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  cfg_t              cfg_live,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              b_valid,
  output logic [BYTE_W-1:0] b_data,
  output logic              b_first,
  output logic              b_wide
);
  logic [IDX_W-1:0] idx_q;
  cfg_t             cfg_q;
  cfg_t             cfg_cur;
  slot_e            kind;
  logic             last;

  assign cfg_cur = (idx_q == '0) ? cfg_live : cfg_q;

  atmtx_slot slot_i (
    .idx  (idx_q),
    .cfg  (cfg_cur),
    .kind (kind),
    .last (last)
  );

  always_comb begin
    in_ready = (kind == SLOT_SRC);
    if (kind == SLOT_SRC)
      b_valid = in_valid;
    else
      b_valid = (idx_q != '0) || in_valid;
    case (kind)
      SLOT_HEC: b_data = cfg_cur.hec_zero ? '0 : cfg_cur.hec_byte;
      SLOT_PAD: b_data = '0;
      default:  b_data = in_data;
    endcase
    b_first = (idx_q == '0);
    b_wide  = !cfg_cur.bus8;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      cfg_q <= '0;
    end else if (b_valid) begin
      if (idx_q == '0) cfg_q <= cfg_live;
      idx_q <= last ? '0 : idx_q + IDX_W'(1);
    end
  end

  // R10: held configuration does not move while a cell is in progress
  a_r10_cfg_held: assert property (@(posedge clk) disable iff (rst)
    (idx_q != '0 && $past(idx_q) != '0) |-> $stable(cfg_q));

  // R12: a stalled input slot holds its position
  a_r12_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> $stable(idx_q));
endmodule

// File: rtl/atmtx_pack.sv
module atmtx_pack
  import atmtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              b_valid,
  input  logic [BYTE_W-1:0] b_data,
  input  logic              b_first,
  input  logic              b_wide,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_valid,
  output logic              tx_soc
);
  logic              phase_q;
  logic [BYTE_W-1:0] hi_q;
  logic              hi_first_q;
  logic              wide_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= 1'b0;
      hi_q       <= '0;
      hi_first_q <= 1'b0;
      wide_q     <= 1'b0;
      tx_data    <= '0;
      tx_valid   <= 1'b0;
      tx_soc     <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      tx_soc   <= 1'b0;
      if (b_valid) begin
        wide_q <= b_wide;
        if (!b_wide) begin
          tx_data  <= {{BYTE_W{1'b0}}, b_data};
          tx_valid <= 1'b1;
          tx_soc   <= b_first;
          phase_q  <= 1'b0;
        end else if (!phase_q) begin
          hi_q       <= b_data;
          hi_first_q <= b_first;
          phase_q    <= 1'b1;
        end else begin
          tx_data  <= {hi_q, b_data};
          tx_valid <= 1'b1;
          tx_soc   <= hi_first_q;
          phase_q  <= 1'b0;
        end
      end
    end
  end

  // R9: start-of-cell never stands alone
  a_r9_soc_with_valid: assert property (@(posedge clk) disable iff (rst)
    tx_soc |-> tx_valid);

  // R5: wide words need two bytes, so never back to back
  a_r5_wide_rate: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && wide_q) |=> !tx_valid);

  // R7: every wide cell begins on a word boundary
  a_r7_cell_starts_even: assert property (@(posedge clk) disable iff (rst)
    (b_valid && b_first && b_wide) |-> !phase_q);
endmodule

// File: rtl/atm_txfmt.sv
module atm_txfmt
  import atmtx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [EXTRA_W-1:0]    cfg_extra,
  input  logic                  cfg_cell52,
  input  logic                  cfg_hec_zero,
  input  logic [BYTE_W-1:0]     cfg_hec_byte,
  input  logic                  cfg_bus8,
  input  logic                  cfg_align,
  input  logic [BYTE_W-1:0]     in_data,
  input  logic                  in_valid,
  output logic                  in_ready,
  output logic [WORD_W-1:0]     tx_data,
  output logic                  tx_valid,
  output logic                  tx_soc
);
  cfg_t              cfg_live;
  logic              b_valid;
  logic [BYTE_W-1:0] b_data;
  logic              b_first;
  logic              b_wide;

  always_comb begin
    cfg_live.extra    = cfg_extra;
    cfg_live.cell52   = cfg_cell52;
    cfg_live.hec_zero = cfg_hec_zero;
    cfg_live.hec_byte = cfg_hec_byte;
    cfg_live.bus8     = cfg_bus8;
    cfg_live.align    = cfg_align;
  end

  atmtx_seq seq_i (
    .clk      (clk),
    .rst      (rst),
    .cfg_live (cfg_live),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .b_valid  (b_valid),
    .b_data   (b_data),
    .b_first  (b_first),
    .b_wide   (b_wide)
  );

  atmtx_pack pack_i (
    .clk      (clk),
    .rst      (rst),
    .b_valid  (b_valid),
    .b_data   (b_data),
    .b_first  (b_first),
    .b_wide   (b_wide),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_soc   (tx_soc)
  );

  // R11: nothing leaves the block while reset is applied
  a_r11_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!tx_valid && !tx_soc));
endmodule

// File: tb/atm_txfmt_tb.sv
module atm_txfmt_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_extra = '0;
  logic        cfg_cell52 = 1'b0;
  logic        cfg_hec_zero = 1'b0;
  logic [7:0]  cfg_hec_byte = 8'h00;
  logic        cfg_bus8 = 1'b0;
  logic        cfg_align = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] tx_data;
  logic        tx_valid;
  logic        tx_soc;

  always #4 clk = ~clk;

  atm_txfmt dut_i (
    .clk(clk), .rst(rst), .cfg_extra(cfg_extra), .cfg_cell52(cfg_cell52),
    .cfg_hec_zero(cfg_hec_zero), .cfg_hec_byte(cfg_hec_byte), .cfg_bus8(cfg_bus8),
    .cfg_align(cfg_align), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_soc(tx_soc)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int cyc = 0;

  logic [15:0] exp_w [0:63];
  int          exp_t [0:63];
  int          exp_n;
  logic [15:0] got_w [0:63];
  logic        got_s [0:63];
  int          got_n = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && tx_valid && got_n < 64) begin
      got_w[got_n] = tx_data;
      got_s[got_n] = tx_soc;
      got_n = got_n + 1;
    end
  end

  function automatic logic [7:0] srcval(input int seed, input int s);
    return 8'((seed * 13 + s * 5 + 1) & 255);
  endfunction

  function automatic string tagname(input int t);
    case (t)
      1: return "R1";
      3: return "R3";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic build(input int ex, input bit c52, input bit hz, input logic [7:0] hb,
                       input bit b8, input bit al, input int seed);
    logic [7:0] eb [0:63];
    int et [0:63];
    int k = 0;
    int s = 0;
    int len = ex + 52 + (c52 ? 0 : 1);
    bit odd = !b8 && (len % 2 == 1);
    bit front = odd && al && (ex != 0);
    if (front) begin eb[k] = 8'h00; et[k] = 7; k++; end
    for (int r = 0; r < ex; r++) begin eb[k] = srcval(seed, s); et[k] = 1; s++; k++; end
    for (int r = 0; r < 4; r++) begin eb[k] = srcval(seed, s); et[k] = 5; s++; k++; end
    if (!c52) begin eb[k] = hz ? 8'h00 : hb; et[k] = 3; k++; end
    for (int r = 0; r < 48; r++) begin eb[k] = srcval(seed, s); et[k] = 5; s++; k++; end
    if (odd && !front) begin eb[k] = 8'h00; et[k] = al ? 8 : 6; k++; end
    exp_n = 0;
    if (b8) begin
      for (int i = 0; i < k; i++) begin
        exp_w[exp_n] = {8'h00, eb[i]};
        exp_t[exp_n] = (al && ex == 0) ? 8 : et[i];
        exp_n++;
      end
    end else begin
      for (int i = 0; i < k; i += 2) begin
        exp_w[exp_n] = {eb[i], eb[i+1]};
        exp_t[exp_n] = (et[i] != 5) ? et[i] : et[i+1];
        exp_n++;
      end
    end
  endtask

  // drive one cell; optional config switch after chg_at bytes taken
  task automatic run_cell(input int ex, input bit c52, input bit hz, input logic [7:0] hb,
                          input bit b8, input bit al, input int seed, input bit gap,
                          input int chg_at, input int n_ex, input bit n_c52, input bit n_b8,
                          input bit n_al);
    int s = 0;
    int wait_c = 0;
    cfg_extra = 2'(ex); cfg_cell52 = c52; cfg_hec_zero = hz; cfg_hec_byte = hb;
    cfg_bus8 = b8; cfg_align = al;
    build(ex, c52, hz, hb, b8, al, seed);
    got_n = 0;
    while (s < ex + 52) begin
      @(negedge clk);
      in_valid = !(gap && (cyc % 4 == 1));
      in_data = srcval(seed, s);
      #1;
      if (in_valid && in_ready) begin
        s++;
        if (s == chg_at) begin
          cfg_extra = 2'(n_ex); cfg_cell52 = n_c52; cfg_bus8 = n_b8; cfg_align = n_al;
          cfg_hec_zero = !hz; cfg_hec_byte = ~hb;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    while (got_n < exp_n && wait_c < 200) begin @(negedge clk); wait_c++; end
    repeat (4) @(negedge clk);
    check(got_n == exp_n, "R2", $sformatf("beat count ex=%0d c52=%0d b8=%0d al=%0d", ex, c52, b8, al),
          got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      check(got_w[i] === exp_w[i], tagname(exp_t[i]),
            $sformatf("beat %0d ex=%0d c52=%0d hz=%0d b8=%0d al=%0d", i, ex, c52, hz, b8, al),
            int'(got_w[i]), int'(exp_w[i]));
      check(got_s[i] === (i == 0), "R9", $sformatf("soc beat %0d", i),
            int'(got_s[i]), (i == 0) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tx_valid == 1'b0 && tx_soc == 1'b0, "R11", "outputs during reset",
          int'({tx_valid, tx_soc}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(tx_valid == 1'b0 && tx_soc == 1'b0, "R11", "outputs after reset",
          int'({tx_valid, tx_soc}), 0);
    // full configuration sweep: R1 R2 R3 R4 R5 R6 R7 R8 R9
    for (int c = 0; c < 64; c++) begin
      run_cell(c & 3, (c >> 2) & 1, (c >> 3) & 1, 8'h5A + 8'(c), (c >> 4) & 1, (c >> 5) & 1,
               c, 1'b0, -1, 0, 1'b0, 1'b0, 1'b0);
    end
    // R12: input stalls at intervals
    for (int c = 0; c < 8; c++) begin
      run_cell(c & 3, 1'b0, 1'b0, 8'hC3, c >= 4, 1'b1, 100 + c, 1'b1, -1, 0, 1'b0, 1'b0, 1'b0);
    end
    // R10: reconfigure mid-cell, then the new setting takes the next cell
    run_cell(3, 1'b0, 1'b0, 8'h77, 1'b0, 1'b1, 200, 1'b0, 10, 0, 1'b1, 1'b1, 1'b0);
    run_cell(0, 1'b1, 1'b1, 8'h88, 1'b1, 1'b0, 201, 1'b0, -1, 0, 1'b0, 1'b0, 1'b0);
    run_cell(1, 1'b0, 1'b1, 8'h11, 1'b1, 1'b0, 202, 1'b1, 20, 2, 1'b1, 1'b0, 1'b1);
    run_cell(2, 1'b1, 1'b0, 8'hEE, 1'b0, 1'b1, 203, 1'b0, -1, 0, 1'b0, 1'b0, 1'b0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog run did not complete actual=%0d expected=0", 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule